// File: doc/BRIEF.md
# Serial Voice Multiplex Mixer

This block turns a set of latched, signed per-voice sample values into one stereo sample pair. It does not sum the voices in parallel. It shows one voice at a time, the way a time-multiplexed audio output would. Each active voice holds the output for a fixed slice of clocks, and the slices visit the voices from the highest index downward. On every clock, the value of the voice on show is weighted by that voice's left gain and right gain, and the results are added into two accumulators. A voice whose mask bit is set adds nothing, but its slice still takes up time.

A downstream consumer asks for a sample with a valid/ready handshake. At the handshake, the block takes a snapshot of both accumulators and of the number of clocks since the previous handshake, then starts a fresh window. A sequential divider forms twice the accumulated sum over that clock count. When the divider finishes, the results appear on registered outputs with a one-cycle valid pulse. Because the output is a time average, each voice gets quieter as more voices become active. A master disable forces both outputs to zero.

Top module: `serial_voice_mixer`

## Requirements
- R1: While reset is high and on the first clock after it, req_ready is 1, smp_valid is 0 and both outputs are 0. Reset sets every voice's left and right gain to 128.
- R2: voice_cnt_m1 + 1 voices are active. Each active voice holds for exactly SLICE (15) clocks. After the slice of the last active voice, the sequence returns to the first slice. Slices that follow one another always run back to back.
- R3: Slice k shows voice NV-1-k. Voice i is the signed VW-bit field voice_vals[i*VW +: VW]. Slice 0 starts on the first clock after reset.
- R4: A voice whose bit voice_mask[i] is 1 adds zero to both accumulators during its slice. Its slice still lasts SLICE clocks.
- R5: On each clock, the left sum gains value × left gain of the voice on show, and the right sum gains value × right gain. Gains are unsigned. A write with gain_we sets both gains of voice gain_sel, and the new gains take effect from the next clock.
- R6: A handshake happens on a clock where req_valid and req_ready are both 1. The result for that handshake is trunc_toward_zero(2·S / N), where S is the sum over the N clocks from the previous handshake clock up to the clock before this one. The first window starts after reset. The result is 0 when N is 0. The handshake clock itself opens the next window.
- R7: From a handshake until its result arrives, req_ready is 0. smp_valid pulses for one clock, and in that same clock the new outputs appear and req_ready returns to 1. Outputs do not change between results, except under R8.
- R8: From the clock after master_dis is seen high, both outputs are 0. A result that completes while master_dis is high is delivered as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| voice_vals | input | NV*VW | Signed latched value of each voice, voice i at bits i*VW |
| voice_cnt_m1 | input | SEL_W | Number of active voices minus one |
| voice_mask | input | NV | Per-voice mute, bit i mutes voice i |
| master_dis | input | 1 | Forces outputs to zero |
| gain_we | input | 1 | Gain write strobe |
| gain_sel | input | SEL_W | Voice whose gains are written |
| gain_l | input | GW | New left gain |
| gain_r | input | GW | New right gain |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Block can accept a request |
| smp_valid | output | 1 | One-clock pulse with a new result |
| smp_left | output | OUT_W | Signed left result |
| smp_right | output | OUT_W | Signed right result |

## Verification
Two cases are hard to reach from the ports. The first is a window of zero clocks. It exists only when a request is already pending as reset is released, so the bench holds req_valid high through reset. The second is the slice order across a wrap that ends part-way through a slice. The bench reaches it with windows whose lengths are not multiples of 15, with a single active voice while every other voice carries a large value, and with all active voices masked. In every case a cycle-level model in the bench, built from the requirements, predicts the truncated quotient for negative and positive sums alike.

// File: rtl/svm_pkg.sv
package svm_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_BUSY = 1'b1 } mix_st_e;
endpackage

// File: rtl/svm_slice_seq.sv
module svm_slice_seq #(
  parameter int NV    = 8,
  parameter int SLICE = 15,
  parameter int SEL_W = $clog2(NV),
  parameter int SUB_W = $clog2(SLICE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] last_slice,
  output logic [SEL_W-1:0] slice_k,
  output logic [SUB_W-1:0] sub_cnt,
  output logic [SEL_W-1:0] voice_idx
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLICE - 1);
  localparam logic [SEL_W-1:0] TOP_IDX  = SEL_W'(NV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_k <= '0;
      sub_cnt <= '0;
    end else if (sub_cnt == SUB_LAST) begin
      sub_cnt <= '0;
      slice_k <= (slice_k >= last_slice) ? '0 : slice_k + 1'b1;
    end else begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  // reversed presentation order
  assign voice_idx = TOP_IDX - slice_k;
endmodule

// File: rtl/svm_gain_bank.sv
module svm_gain_bank #(
  parameter int NV       = 8,
  parameter int GW       = 8,
  parameter int GAIN_RST = 128,
  parameter int SEL_W    = $clog2(NV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [GW-1:0]    wr_l,
  input  logic [GW-1:0]    wr_r,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [GW-1:0]    rd_l,
  output logic [GW-1:0]    rd_r
);
  logic [GW-1:0] g_l [NV];
  logic [GW-1:0] g_r [NV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NV; i++) begin
        g_l[i] <= GW'(GAIN_RST);
        g_r[i] <= GW'(GAIN_RST);
      end
    end else if (wr_en) begin
      g_l[wr_idx] <= wr_l;
      g_r[wr_idx] <= wr_r;
    end
  end

  assign rd_l = g_l[rd_idx];
  assign rd_r = g_r[rd_idx];
endmodule

// File: rtl/svm_seq_div.sv
module svm_seq_div #(
  parameter int NUM_W  = 30,
  parameter int DEN_W  = 13,
  parameter int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    num_neg,
  input  logic [NUM_W-1:0]        num_mag,
  input  logic [DEN_W-1:0]        den,
  output logic                    done,
  output logic signed [NUM_W-1:0] quo
);
  logic [NUM_W-1:0]  q_sh;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  den_r;
  logic              neg_r;
  logic              zero_r;
  logic [STEP_W-1:0] steps;

  logic [DEN_W:0]   rem_sh;
  logic             fits;
  logic [DEN_W:0]   rem_diff;
  logic [NUM_W-1:0] q_nx;

  always_comb begin
    rem_sh   = {rem, q_sh[NUM_W-1]};
    fits     = rem_sh >= {1'b0, den_r};
    rem_diff = rem_sh - {1'b0, den_r};
    q_nx     = {q_sh[NUM_W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_sh   <= '0;
      rem    <= '0;
      den_r  <= '0;
      neg_r  <= 1'b0;
      zero_r <= 1'b0;
      steps  <= '0;
      done   <= 1'b0;
      quo    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_sh   <= num_mag;
        rem    <= '0;
        den_r  <= den;
        neg_r  <= num_neg;
        zero_r <= (den == '0);
        steps  <= STEP_W'(NUM_W);
      end else if (steps != '0) begin
        q_sh  <= q_nx;
        rem   <= fits ? rem_diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        steps <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          done <= 1'b1;
          if (zero_r)     quo <= '0;
          else if (neg_r) quo <= -$signed(q_nx);
          else            quo <= $signed(q_nx);
        end
      end
    end
  end
endmodule

// File: rtl/serial_voice_mixer.sv
module serial_voice_mixer #(
  parameter int NV       = 8,
  parameter int VW       = 8,
  parameter int GW       = 8,
  parameter int SLICE    = 15,
  parameter int WIN_MAX  = 4096,
  parameter int GAIN_RST = 128,
  parameter int SEL_W    = $clog2(NV),
  parameter int PROD_W   = VW + GW + 1,
  parameter int OUT_W    = PROD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NV*VW-1:0]        voice_vals,
  input  logic [SEL_W-1:0]        voice_cnt_m1,
  input  logic [NV-1:0]           voice_mask,
  input  logic                    master_dis,
  input  logic                    gain_we,
  input  logic [SEL_W-1:0]        gain_sel,
  input  logic [GW-1:0]           gain_l,
  input  logic [GW-1:0]           gain_r,
  input  logic                    req_valid,
  output logic                    req_ready,
  output logic                    smp_valid,
  output logic signed [OUT_W-1:0] smp_left,
  output logic signed [OUT_W-1:0] smp_right
);
  import svm_pkg::*;

  localparam int SUB_W = $clog2(SLICE);
  localparam int CNT_W = $clog2(WIN_MAX + 1);
  localparam int ACC_W = PROD_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIN_MAX);

  logic [SEL_W-1:0] slice_k;
  logic [SUB_W-1:0] sub_cnt;
  logic [SEL_W-1:0] voice_idx;
  logic [GW-1:0]    cur_gl;
  logic [GW-1:0]    cur_gr;

  svm_slice_seq #(.NV(NV), .SLICE(SLICE), .SEL_W(SEL_W), .SUB_W(SUB_W)) u_seq (
    .clk(clk), .rst(rst), .last_slice(voice_cnt_m1),
    .slice_k(slice_k), .sub_cnt(sub_cnt), .voice_idx(voice_idx)
  );

  svm_gain_bank #(.NV(NV), .GW(GW), .GAIN_RST(GAIN_RST), .SEL_W(SEL_W)) u_gain (
    .clk(clk), .rst(rst), .wr_en(gain_we), .wr_idx(gain_sel),
    .wr_l(gain_l), .wr_r(gain_r), .rd_idx(voice_idx),
    .rd_l(cur_gl), .rd_r(cur_gr)
  );

  // weighted contribution of the voice on show
  logic signed [VW-1:0]     cur_val;
  logic signed [PROD_W-1:0] prod_l, prod_r;
  logic signed [ACC_W-1:0]  add_l, add_r;

  always_comb begin
    cur_val = $signed(voice_vals[voice_idx*VW +: VW]);
    prod_l  = PROD_W'(cur_val * $signed({1'b0, cur_gl}));
    prod_r  = PROD_W'(cur_val * $signed({1'b0, cur_gr}));
    if (voice_mask[voice_idx]) begin
      add_l = '0;
      add_r = '0;
    end else begin
      add_l = ACC_W'(prod_l);
      add_r = ACC_W'(prod_r);
    end
  end

  mix_st_e                 st;
  logic                    hs;
  logic signed [ACC_W-1:0] acc_l, acc_r;
  logic [CNT_W-1:0]        win_cnt;

  assign req_ready = (st == ST_IDLE);
  assign hs        = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_l   <= '0;
      acc_r   <= '0;
      win_cnt <= '0;
    end else if (hs) begin
      acc_l   <= add_l;
      acc_r   <= add_r;
      win_cnt <= CNT_W'(1);
    end else begin
      acc_l   <= acc_l + add_l;
      acc_r   <= acc_r + add_r;
      win_cnt <= (win_cnt == CNT_TOP) ? win_cnt : win_cnt + 1'b1;
    end
  end

  // magnitudes of twice the sums feed the two dividers
  logic [ACC_W-1:0] mag_l, mag_r;
  always_comb begin
    mag_l = acc_l[ACC_W-1] ? ACC_W'(-acc_l) : ACC_W'(acc_l);
    mag_r = acc_r[ACC_W-1] ? ACC_W'(-acc_r) : ACC_W'(acc_r);
  end

  logic [1:0]              div_done;
  logic signed [ACC_W-1:0] div_q [2];
  logic [ACC_W-1:0]        div_num [2];
  logic [1:0]              div_neg;

  assign div_num[0] = {mag_l[ACC_W-2:0], 1'b0};
  assign div_num[1] = {mag_r[ACC_W-2:0], 1'b0};
  assign div_neg    = {acc_r[ACC_W-1], acc_l[ACC_W-1]};

  for (genvar c = 0; c < 2; c++) begin : g_div
    svm_seq_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
      .clk(clk), .rst(rst), .start(hs), .num_neg(div_neg[c]),
      .num_mag(div_num[c]), .den(win_cnt),
      .done(div_done[c]), .quo(div_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (hs) st <= ST_BUSY;
      if (div_done[0]) begin
        st        <= ST_IDLE;
        smp_valid <= 1'b1;
        smp_left  <= master_dis ? '0 : div_q[0][OUT_W-1:0];
        smp_right <= master_dis ? '0 : div_q[1][OUT_W-1:0];
      end else if (master_dis) begin
        smp_left  <= '0;
        smp_right <= '0;
      end
    end
  end
endmodule

// File: rtl/svm_checker.sv
module svm_checker #(
  parameter int NV    = 8,
  parameter int SLICE = 15,
  parameter int ACC_W = 30,
  parameter int OUT_W = 17,
  parameter int SEL_W = $clog2(NV),
  parameter int SUB_W = $clog2(SLICE)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    smp_valid,
  input logic signed [OUT_W-1:0] smp_left,
  input logic signed [OUT_W-1:0] smp_right,
  input logic                    master_dis,
  input logic [NV-1:0]           voice_mask,
  input logic [SEL_W-1:0]        voice_cnt_m1,
  input logic [SEL_W-1:0]        slice_k,
  input logic [SUB_W-1:0]        sub_cnt,
  input logic [SEL_W-1:0]        voice_idx,
  input logic signed [ACC_W-1:0] acc_l,
  input logic signed [ACC_W-1:0] acc_r
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLICE - 1);

  p_rst_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !smp_valid && smp_left == '0 && smp_right == '0));

  p_slice_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sub_cnt != SUB_LAST) |=> $stable(slice_k));

  p_slice_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (sub_cnt == SUB_LAST && slice_k >= voice_cnt_m1) |=> (slice_k == '0 && sub_cnt == '0));

  p_mask_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (voice_mask[voice_idx] && !(req_valid && req_ready)) |=>
      (acc_l == $past(acc_l) && acc_r == $past(acc_r)));

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  p_ready_back_r7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !master_dis |=> (smp_valid || ($stable(smp_left) && $stable(smp_right))));

  p_dis_zero_r8: assert property (@(posedge clk) disable iff (rst)
    master_dis |=> (smp_left == '0 && smp_right == '0));
endmodule

bind serial_voice_mixer svm_checker #(
  .NV(NV), .SLICE(SLICE), .ACC_W(ACC_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
  .master_dis(master_dis), .voice_mask(voice_mask), .voice_cnt_m1(voice_cnt_m1),
  .slice_k(slice_k), .sub_cnt(sub_cnt), .voice_idx(voice_idx),
  .acc_l(acc_l), .acc_r(acc_r)
);

// File: tb/sim_serial_voice_mixer.sv
module sim_serial_voice_mixer;
  localparam int CLK_P = 10;
  localparam int NV = 8, VW = 8, GW = 8, SLICE = 15, WIN_MAX = 4096;
  localparam int SEL_W = 3, OUT_W = VW + GW + 1;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic                    rst;
  logic [NV*VW-1:0]        voice_vals;
  logic [SEL_W-1:0]        voice_cnt_m1;
  logic [NV-1:0]           voice_mask;
  logic                    master_dis, gain_we, req_valid;
  logic [SEL_W-1:0]        gain_sel;
  logic [GW-1:0]           gain_l, gain_r;
  logic                    req_ready, smp_valid;
  logic signed [OUT_W-1:0] smp_left, smp_right;

  serial_voice_mixer u0 (
    .clk(clk), .rst(rst), .voice_vals(voice_vals), .voice_cnt_m1(voice_cnt_m1),
    .voice_mask(voice_mask), .master_dis(master_dis), .gain_we(gain_we),
    .gain_sel(gain_sel), .gain_l(gain_l), .gain_r(gain_r),
    .req_valid(req_valid), .req_ready(req_ready), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { string tag; longint el; longint er; } exp_t;
  exp_t sbq[$];
  string cur_tag = "R6";

  // requirement-level model, evaluated half a cycle before each edge
  int     mk, msub, mcnt;
  longint macc_l, macc_r;
  int     mgl [NV];
  int     mgr [NV];

  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      if (sbq.size() == 0) check("R7 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " left"},  longint'(smp_left),  e.el);
        check({e.tag, " right"}, longint'(smp_right), e.er);
      end
    end
    if (rst) begin
      mk = 0; msub = 0; mcnt = 0; macc_l = 0; macc_r = 0;
      for (int i = 0; i < NV; i++) begin mgl[i] = 128; mgr[i] = 128; end
    end else begin
      int     v;
      longint cl, cr, val;
      v   = NV - 1 - mk;
      val = longint'($signed(voice_vals[v*VW +: VW]));
      cl  = voice_mask[v] ? 0 : val * mgl[v];
      cr  = voice_mask[v] ? 0 : val * mgr[v];
      if (req_valid && req_ready) begin
        exp_t e;
        e.tag = cur_tag;
        e.el  = (mcnt == 0 || master_dis) ? 0 : (2 * macc_l) / mcnt;
        e.er  = (mcnt == 0 || master_dis) ? 0 : (2 * macc_r) / mcnt;
        sbq.push_back(e);
        macc_l = cl; macc_r = cr; mcnt = 1;
      end else begin
        macc_l += cl; macc_r += cr;
        if (mcnt < WIN_MAX) mcnt++;
      end
      if (gain_we) begin mgl[gain_sel] = gain_l; mgr[gain_sel] = gain_r; end
      if (msub == SLICE - 1) begin
        msub = 0;
        mk = (mk >= voice_cnt_m1) ? 0 : mk + 1;
      end else msub++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_voice(int i, int val);
    voice_vals[i*VW +: VW] = VW'(val);
  endtask

  task automatic write_gain(int i, int gl, int gr);
    @(posedge clk); #1;
    gain_we = 1'b1; gain_sel = SEL_W'(i); gain_l = GW'(gl); gain_r = GW'(gr);
    @(posedge clk); #1;
    gain_we = 1'b0;
  endtask

  // driver: issue a request, check the busy phase, wait for the result
  task automatic do_req(string tag);
    @(posedge clk); #1;
    cur_tag   = tag;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 ready low while busy", longint'(req_ready), 0);
    while (!smp_valid) @(negedge clk);
    @(negedge clk);
    check("R7 valid is one pulse", longint'(smp_valid), 0);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic signed [OUT_W-1:0] hl, hr;
    rst = 1'b1; voice_vals = '0; voice_cnt_m1 = 3'd7; voice_mask = '0;
    master_dis = 1'b0; gain_we = 1'b0; gain_sel = '0; gain_l = '0; gain_r = '0;
    req_valid = 1'b1;  // pending across reset: zero-length window (R6)
    cur_tag = "R6 zero window";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", longint'(req_ready), 1);
    check("R1 valid in reset", longint'(smp_valid), 0);
    check("R1 left in reset",  longint'(smp_left), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", longint'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!smp_valid) @(negedge clk);
    step(1);

    // default gains, all eight voices
    for (int i = 0; i < NV; i++) set_voice(i, 10 * i - 35);
    step(200);
    do_req("R1 R2 R3 R5 R6 default gains");

    // distinct gains, three voices, window not a slice multiple
    for (int i = 0; i < NV; i++) write_gain(i, 17 + 29 * i, 250 - 23 * i);
    voice_cnt_m1 = 3'd2;
    for (int i = 0; i < NV; i++) set_voice(i, (i % 2 == 0) ? 120 : -105);
    step(97);
    do_req("R2 R3 R5 R6 three voices");

    // one active voice, others loud: only voice 7 may appear
    voice_cnt_m1 = 3'd0;
    for (int i = 0; i < NV - 1; i++) set_voice(i, 127);
    set_voice(7, -7);
    step(53);
    do_req("R3 R6 single voice negative");

    // masked voices keep their slices
    voice_cnt_m1 = 3'd3;
    voice_mask = 8'b1010_0000;
    for (int i = 0; i < NV; i++) set_voice(i, 3 + 11 * i);
    step(131);
    do_req("R4 R2 partial mask");
    voice_mask = 8'b1111_0000;
    step(70);
    do_req("R4 all active masked");
    voice_mask = '0;

    // values and count changing inside the window
    voice_cnt_m1 = 3'd5;
    for (int j = 0; j < 12; j++) begin
      for (int i = 0; i < NV; i++) set_voice(i, ((j * 37 + i * 19) % 226) - 105);
      step(7 + j);
    end
    do_req("R5 R6 varying inputs");

    // outputs hold between results
    hl = smp_left; hr = smp_right;
    for (int i = 0; i < NV; i++) set_voice(i, -60 + i);
    step(20);
    check("R7 left held",  longint'(smp_left),  longint'(hl));
    check("R7 right held", longint'(smp_right), longint'(hr));

    // master disable
    master_dis = 1'b1;
    step(2);
    check("R8 left zero when disabled",  longint'(smp_left),  0);
    check("R8 right zero when disabled", longint'(smp_right), 0);
    step(40);
    do_req("R8 result while disabled");
    master_dis = 1'b0;
    step(10);
    check("R7 hold after disable left", longint'(smp_left), 0);
    step(80);
    do_req("R6 after disable");

    // full eight voices, maximum gains
    voice_cnt_m1 = 3'd7;
    for (int i = 0; i < NV; i++) begin
      write_gain(i, 255, 1);
      set_voice(i, (i < 4) ? 120 : -105);
    end
    step(300);
    do_req("R2 R5 R6 max gain");

    step(5);
    check("R7 no pending results", longint'(sbq.size()), 0);
    finish_up();
  end
endmodule